// File: doc/BRIEF.md
# Bit-Parallel Stuck-At Fault Grading Engine

This block grades single stuck-at faults on one small, fixed combinational netlist. It evaluates every line of that netlist as a W-bit word. Bit 0 of each word is the fault-free machine. Bit k, for k from 1 to W-1, is a copy of the circuit that carries the k-th fault of the current pass. So one evaluation of the netlist grades W-1 faults against one test vector at once.

A pass starts when a fault table of W-1 slots is presented with a start pulse. Each slot names a line and the value it is stuck at, and a per-slot valid mask marks unused slots in the last pass. Test vectors then stream in, one per cycle. For each accepted vector the block reports which faults showed a difference at a primary output. It keeps a bitmap of the faults detected in the pass. With dropping on, it stops reporting faults it has already detected and ends the pass early once every valid fault is covered. With dropping off, every vector is graded for diagnosis. Two running counters, faults detected and faults loaded, let the caller compute coverage over many passes.

Top module: `pfsim_engine`

## Requirements
- R1: The netlist is fixed. Lines n0, n1 and n2 are primary inputs driven by vecIn bits 0, 1 and 2. n3 = n0 AND n1, n4 = NOT(n1 AND n2), n5 = n3 OR n4, n6 = n3 XOR n2. The primary outputs are n5 and n6. Slot k (k = 1..W-1) is described by faultTable bits [4(k-1)+3 : 4(k-1)]. Bits [2:0] of a slot give the line index 0..6, and bit 3 gives the stuck value. The stuck value replaces that line's bit k before any gate that reads the line is evaluated.
- R2: On a passStart cycle the block latches the fault table, faultValid and noDropIn. It clears detectedMap, adds the number of set faultValid bits to totalFaults, and shows busy high from the next cycle. A vector presented in the same cycle as passStart is not graded.
- R3: A vector accepted while busy (vecValid high, passStart low) gives detValid high one cycle later. In that cycle, detMask bit k-1 is set when slot k's fault makes either primary output differ from the fault-free value, subject to R4 and R5. When detValid is low, detMask is zero.
- R4: A slot whose faultValid bit was 0 at passStart is never reported in detMask or detectedMap, and never counted.
- R5: With dropping enabled (noDropIn low at passStart), a fault already in detectedMap is not reported again. In the cycle where detectedMap first covers every valid slot, passDone pulses and busy falls, so later vectors are not graded.
- R6: With dropping suppressed (noDropIn high at passStart), every detecting vector reports all of its detected faults, including faults reported earlier. The pass ends only on vecLast.
- R7: An accepted vector with vecLast high ends the pass. passDone is high for that one result cycle, and busy is low from that cycle on.
- R8: Vectors presented while busy is low are ignored. detValid stays low, and detectedMap and detCount do not change.
- R9: detectedMap accumulates the detections of the pass. detCount rises by the number of faults detected for the first time in the pass. It never exceeds totalFaults.
- R10: After reset, busy, passDone and detValid are low, and detMask, detectedMap, detCount and totalFaults are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| passStart | input | 1 | Starts a pass and latches the fault table, valid mask and mode |
| noDropIn | input | 1 | 1 = suppress fault dropping for this pass |
| faultTable | input | 4*(W-1) | W-1 slots of {stuck value, line index[2:0]} |
| faultValid | input | W-1 | Per-slot valid mask, bit k-1 for slot k |
| vecValid | input | 1 | A test vector is present |
| vecIn | input | 3 | Primary input values |
| vecLast | input | 1 | Marks the last vector of the pass |
| busy | output | 1 | A pass is running |
| passDone | output | 1 | One-cycle pulse when a pass ends |
| detValid | output | 1 | detMask holds the result of a vector |
| detMask | output | W-1 | Faults detected by the vector, bit k-1 for slot k |
| detectedMap | output | W-1 | Faults detected so far in the pass |
| detCount | output | CNT_W | Running count of detected faults |
| totalFaults | output | CNT_W | Running count of faults loaded |

## Verification
Every result of an accepted vector, meaning detValid, detMask, detectedMap, detCount, passDone and the fall of busy, lands on the first rising edge after the vector is presented. totalFaults and the rise of busy land on the first edge after passStart. The bench drives each input on a falling edge and checks the results on the next falling edge. At that point exactly one register stage has updated, so each check lines up with the edge its requirement names. Expected masks come from a behavioural model of the R1 netlist that forces one line per slot and tracks its own drop bitmap and counters.

// File: rtl/pfsim_pkg.sv
package pfsim_pkg;
  localparam int NUM_PI    = 3;
  localparam int NUM_PO    = 2;
  localparam int NUM_LINES = 7;
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int ENTRY_W   = LINE_W + 1;

  typedef struct packed {
    logic loadPass;  // latch a new fault table
    logic evalVec;   // grade the presented vector
    logic keepAll;   // dropping suppressed in this pass
  } pfsim_strobe_t;
endpackage

// File: rtl/pfsim_netlist.sv
module pfsim_netlist
  import pfsim_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [NUM_PI-1:0]               vecIn,
  input  logic [NUM_LINES-1:0][W-1:0]     mask0,
  input  logic [NUM_LINES-1:0][W-1:0]     mask1,
  output logic [NUM_PO-1:0][W-1:0]        poWord
);
  function automatic logic [W-1:0] applyForce(input logic [W-1:0] v,
                                              input logic [W-1:0] z,
                                              input logic [W-1:0] o);
    return (v & ~z) | o;
  endfunction

  logic [W-1:0] n0, n1, n2, n3, n4, n5, n6;

  // primary inputs are broadcast to every machine, then forced
  assign n0 = applyForce({W{vecIn[0]}}, mask0[0], mask1[0]);
  assign n1 = applyForce({W{vecIn[1]}}, mask0[1], mask1[1]);
  assign n2 = applyForce({W{vecIn[2]}}, mask0[2], mask1[2]);
  // gates, each output forced before its readers see it
  assign n3 = applyForce(n0 & n1,    mask0[3], mask1[3]);
  assign n4 = applyForce(~(n1 & n2), mask0[4], mask1[4]);
  assign n5 = applyForce(n3 | n4,    mask0[5], mask1[5]);
  assign n6 = applyForce(n3 ^ n2,    mask0[6], mask1[6]);

  assign poWord[0] = n5;
  assign poWord[1] = n6;
endmodule

// File: rtl/pfsim_ctrl.sv
module pfsim_ctrl
  import pfsim_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          passStart,
  input  logic          noDropIn,
  input  logic          vecValid,
  input  logic          vecLast,
  input  logic          allCovered,
  output pfsim_strobe_t strobe,
  output logic          busy,
  output logic          passDone
);
  typedef enum logic {ST_IDLE, ST_RUN} pass_state_t;
  pass_state_t stateQ;
  logic        keepAllQ;
  logic        endPass;

  always_comb begin
    strobe.loadPass = passStart;
    strobe.evalVec  = !passStart && (stateQ == ST_RUN) && vecValid;
    strobe.keepAll  = keepAllQ;
    endPass         = strobe.evalVec && (vecLast || (!keepAllQ && allCovered));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      keepAllQ <= 1'b0;
      passDone <= 1'b0;
    end else begin
      passDone <= endPass;
      if (strobe.loadPass) begin
        stateQ   <= ST_RUN;
        keepAllQ <= noDropIn;
      end else if (endPass) begin
        stateQ   <= ST_IDLE;
      end
    end
  end

  assign busy = (stateQ == ST_RUN);
endmodule

// File: rtl/pfsim_datapath.sv
module pfsim_datapath
  import pfsim_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pfsim_strobe_t             strobe,
  input  logic [(W-1)*ENTRY_W-1:0]  faultTable,
  input  logic [W-2:0]              faultValid,
  input  logic [NUM_PI-1:0]         vecIn,
  output logic                      allCovered,
  output logic                      detValid,
  output logic [W-2:0]              detMask,
  output logic [W-2:0]              detectedMap,
  output logic [CNT_W-1:0]          detCount,
  output logic [CNT_W-1:0]          totalFaults
);
  localparam int SLOTS = W - 1;

  logic [NUM_LINES-1:0][W-1:0] m0Next, m1Next, m0Q, m1Q;
  logic [SLOTS-1:0]            validQ;
  logic [NUM_PO-1:0][W-1:0]    poWord;
  logic [W-1:0]                diffAll;
  logic [SLOTS-1:0]            faultDiff, newHits, report, mapNext;

  // force masks: slot sl drives bit sl of its line's mask
  for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
    assign m0Next[ln][0] = 1'b0;
    assign m1Next[ln][0] = 1'b0;
    for (genvar sl = 1; sl < W; sl++) begin : g_slot
      logic [ENTRY_W-1:0] ent;
      logic               hit;
      assign ent = faultTable[(sl-1)*ENTRY_W +: ENTRY_W];
      assign hit = faultValid[sl-1] && (ent[LINE_W-1:0] == LINE_W'(ln));
      assign m0Next[ln][sl] = hit && !ent[ENTRY_W-1];
      assign m1Next[ln][sl] = hit &&  ent[ENTRY_W-1];
    end
  end

  pfsim_netlist #(.W(W)) u_netlist (
    .vecIn  (vecIn),
    .mask0  (m0Q),
    .mask1  (m1Q),
    .poWord (poWord)
  );

  // compare every machine with bit 0 at each primary output
  always_comb begin
    diffAll = '0;
    for (int p = 0; p < NUM_PO; p++) begin
      diffAll = diffAll | (poWord[p] ^ {W{poWord[p][0]}});
    end
    faultDiff  = diffAll[W-1:1] & validQ;
    newHits    = faultDiff & ~detectedMap;
    report     = strobe.keepAll ? faultDiff : newHits;
    mapNext    = detectedMap | newHits;
    allCovered = ((mapNext & validQ) == validQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m0Q         <= '0;
      m1Q         <= '0;
      validQ      <= '0;
      detValid    <= 1'b0;
      detMask     <= '0;
      detectedMap <= '0;
      detCount    <= '0;
      totalFaults <= '0;
    end else begin
      detValid <= 1'b0;
      detMask  <= '0;
      if (strobe.loadPass) begin
        m0Q         <= m0Next;
        m1Q         <= m1Next;
        validQ      <= faultValid;
        detectedMap <= '0;
        totalFaults <= totalFaults + CNT_W'($countones(faultValid));
      end else if (strobe.evalVec) begin
        detValid    <= 1'b1;
        detMask     <= report;
        detectedMap <= mapNext;
        detCount    <= detCount + CNT_W'($countones(newHits));
      end
    end
  end
endmodule

// File: rtl/pfsim_engine.sv
module pfsim_engine
  import pfsim_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        passStart,
  input  logic                        noDropIn,
  input  logic [(W-1)*ENTRY_W-1:0]    faultTable,
  input  logic [W-2:0]                faultValid,
  input  logic                        vecValid,
  input  logic [NUM_PI-1:0]           vecIn,
  input  logic                        vecLast,
  output logic                        busy,
  output logic                        passDone,
  output logic                        detValid,
  output logic [W-2:0]                detMask,
  output logic [W-2:0]                detectedMap,
  output logic [CNT_W-1:0]            detCount,
  output logic [CNT_W-1:0]            totalFaults
);
  pfsim_strobe_t strobe;
  logic          allCovered;

  pfsim_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .passStart  (passStart),
    .noDropIn   (noDropIn),
    .vecValid   (vecValid),
    .vecLast    (vecLast),
    .allCovered (allCovered),
    .strobe     (strobe),
    .busy       (busy),
    .passDone   (passDone)
  );

  pfsim_datapath #(.W(W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .faultTable  (faultTable),
    .faultValid  (faultValid),
    .vecIn       (vecIn),
    .allCovered  (allCovered),
    .detValid    (detValid),
    .detMask     (detMask),
    .detectedMap (detectedMap),
    .detCount    (detCount),
    .totalFaults (totalFaults)
  );
endmodule

// File: rtl/pfsim_engine_chk.sv
module pfsim_engine_chk
  import pfsim_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     passStart,
  input logic [W-2:0]             faultValid,
  input logic                     busy,
  input logic                     passDone,
  input logic                     detValid,
  input logic [W-2:0]             detMask,
  input logic [W-2:0]             detectedMap,
  input logic [CNT_W-1:0]         detCount,
  input logic [CNT_W-1:0]         totalFaults
);
  logic [W-2:0] validSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validSeen <= '0;
    else if (passStart) validSeen <= faultValid;
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    passStart |=> (busy && detectedMap == '0)); // R2
  AST_QUIET_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !detValid |-> (detMask == '0)); // R3
  AST_UNUSED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (detectedMap & ~validSeen) == '0); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    passDone |-> !busy); // R5
  AST_RESULT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    detValid |-> $past(busy)); // R8
  AST_MASK_IN_MAP: assert property (@(posedge clk) disable iff (!rstN)
    (detMask & ~detectedMap) == '0); // R9
  AST_MAP_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    !passStart |=> (($past(detectedMap) & ~detectedMap) == '0)); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    detCount <= totalFaults); // R9
endmodule

bind pfsim_engine pfsim_engine_chk #(.W(W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/pfsim_engine_bench.sv
module pfsim_engine_bench;
  localparam int W      = 8;
  localparam int CNT_W  = 16;
  localparam int SLOTS  = W - 1;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC   = 8;
  // {vecLast, vecIn[2:0]}
  localparam logic [3:0] VEC_TAB [NVEC] = '{
    4'b0_000, 4'b0_111, 4'b0_101, 4'b0_010,
    4'b0_110, 4'b0_001, 4'b0_011, 4'b1_100
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic passStart = 1'b0, noDropIn = 1'b0, vecValid = 1'b0, vecLast = 1'b0;
  logic [SLOTS*4-1:0] faultTable = '0;
  logic [SLOTS-1:0]   faultValid = '0;
  logic [2:0]         vecIn = '0;
  logic busy, passDone, detValid;
  logic [SLOTS-1:0] detMask, detectedMap;
  logic [CNT_W-1:0] detCount, totalFaults;

  int checks = 0, failures = 0;
  bit finished = 0;

  int   slotLine [SLOTS];
  logic slotSv   [SLOTS];
  logic [SLOTS-1:0] expMap = '0, expValid = '0;
  int   expCount = 0, expTotal = 0;
  bit   expBusy = 0, expKeep = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfsim_engine #(.W(W), .CNT_W(CNT_W)) u_pfsim_engine (.*);

  // behavioural model of the R1 netlist with one forced line (fl<0: none)
  function automatic logic [1:0] modelPo(logic [2:0] v, int fl, logic fv);
    logic [6:0] n;
    n[0] = (fl == 0) ? fv : v[0];
    n[1] = (fl == 1) ? fv : v[1];
    n[2] = (fl == 2) ? fv : v[2];
    n[3] = (fl == 3) ? fv : (n[0] & n[1]);
    n[4] = (fl == 4) ? fv : ~(n[1] & n[2]);
    n[5] = (fl == 5) ? fv : (n[3] | n[4]);
    n[6] = (fl == 6) ? fv : (n[3] ^ n[2]);
    return {n[6], n[5]};
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic loadPass(logic [SLOTS-1:0] valid, logic keep);
    for (int s = 0; s < SLOTS; s++)
      faultTable[s*4 +: 4] = {slotSv[s], 3'(slotLine[s])};
    faultValid = valid;
    noDropIn   = keep;
    passStart  = 1'b1;
    @(negedge clk);
    passStart  = 1'b0;
    expMap = '0; expValid = valid; expKeep = keep; expBusy = 1;
    expTotal += $countones(valid);
    check("R2", "busy after start", busy, 1);
    check("R2", "map cleared", detectedMap, 0);
    check("R2", "totalFaults", totalFaults, expTotal);
  endtask

  task automatic sendVec(logic [2:0] v, logic last, string req);
    logic [SLOTS-1:0] diff, fresh, rep;
    bit   expDet, expDone;
    logic [1:0] good;
    good = modelPo(v, -1, 1'b0);
    diff = '0;
    for (int s = 0; s < SLOTS; s++)
      diff[s] = expValid[s] && (modelPo(v, slotLine[s], slotSv[s]) != good);
    fresh = diff & ~expMap;
    rep   = expKeep ? diff : fresh;
    expDet = expBusy; expDone = 0;
    if (expBusy) begin
      expMap |= fresh;
      expCount += $countones(fresh);
      if (last || (!expKeep && ((expMap & expValid) == expValid))) begin
        expDone = 1; expBusy = 0;
      end
    end else rep = '0;
    vecIn = v; vecLast = last; vecValid = 1'b1;
    @(negedge clk);
    vecValid = 1'b0; vecLast = 1'b0;
    check(req, "detValid", detValid, expDet);
    check(req, "detMask", detMask, rep);
    check("R9", "detectedMap", detectedMap, expMap);
    check("R9", "detCount", detCount, expCount);
    check(req, "passDone", passDone, expDone);
    check(req, "busy", busy, expBusy);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "busy", busy, 0);
    check("R10", "passDone", passDone, 0);
    check("R10", "detValid", detValid, 0);
    check("R10", "detMask", detMask, 0);
    check("R10", "detCount", detCount, 0);
    check("R10", "totalFaults", totalFaults, 0);

    // R8: vector before any pass is ignored
    sendVec(3'b111, 1'b0, "R8");

    // pass A: dropping on, all seven slots valid (R1, R3, R5)
    slotLine = '{3, 4, 5, 6, 0, 2, 1};
    slotSv   = '{0, 1, 0, 1, 1, 0, 1};
    loadPass('1, 1'b0);
    for (int i = 0; i < NVEC; i++)
      sendVec(VEC_TAB[i][2:0], VEC_TAB[i][3], "R5");
    // R8: after the pass ended, more vectors are ignored
    sendVec(3'b011, 1'b0, "R8");

    // pass B: dropping off, three valid slots; unused ones would detect (R4, R6, R7)
    slotLine = '{5, 6, 3, 5, 6, 4, 0};
    slotSv   = '{0, 1, 1, 1, 0, 0, 1};
    loadPass(7'b0000111, 1'b1);
    for (int i = 0; i < 4; i++)
      sendVec(VEC_TAB[i][2:0], (i == 3), (i == 3) ? "R7" : "R6");

    // pass C: vector together with passStart is not graded (R2)
    slotLine = '{1, 0, 0, 0, 0, 0, 0};
    slotSv   = '{0, 0, 0, 0, 0, 0, 0};
    for (int s = 0; s < SLOTS; s++)
      faultTable[s*4 +: 4] = {slotSv[s], 3'(slotLine[s])};
    vecIn = 3'b111; vecValid = 1'b1;
    loadPass(7'b0000001, 1'b0);
    vecValid = 1'b0;
    check("R2", "no result with start", detValid, 0);
    check("R2", "count unchanged", detCount, expCount);
    sendVec(3'b111, 1'b1, "R3");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule